// File: doc/BRIEF.md
# Two-Region Page Table Walker

This block turns a logical address into a physical address by reading one page-table entry from memory. The page number is split off the logical address, checked against the active region's bound, and used to index a table whose base sits in a context register. The entry found there supplies a frame number, a valid flag and a write-permission flag. The result is either a physical address or one of three fault codes.

The logical space is split by its most significant bit. A clear top bit picks the low region, whose bound is the largest page number allowed. A set top bit picks the high region, meant for a downward-growing stack, whose bound is the smallest page number allowed. A context switch is one cycle of `ctx_load`, which rewrites all four base and bound registers together.

A good translation marks the entry as referenced, and also as dirty on a write. The updated entry goes back to memory only when one of those bits actually changes. Requests and responses use valid/ready handshakes. `req_ready` stays low while a walk is in progress, so only one translation is ever in flight. A response waits with its values frozen until `rsp_ready` is high. The memory read request and the entry write-back also hold steady until their ready is seen. Read data comes back on `mrd_rvalid` some cycles after the read is accepted, and that return path cannot be stalled.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `mrd_valid` and `mwr_valid` are 0.
- R2: With address bit VA_W-1 clear, a page number (address bits VA_W-1..OFF_W) greater than the low bound gives fault code 1 (range) with no memory read issued; a page number equal to the bound is translated.
- R3: With address bit VA_W-1 set, a page number smaller than the high bound gives fault code 1 with no memory read; a page number equal to the bound is translated.
- R4: The entry is read at the selected region's base plus four times the page number.
- R5: An entry with bit 0 (valid) clear gives fault code 2 (invalid). Every faulting response carries a physical address of 0.
- R6: A write to a valid entry whose bit 1 (writable) is clear gives fault code 3 (protection); a read of that entry translates.
- R7: A translation without fault returns fault code 0 and a physical address made of the entry's frame field (bits starting at bit 4) above the unchanged byte offset (the low OFF_W address bits).
- R8: On success the entry is written back to the same address with bit 2 (referenced) set, and bit 3 (dirty) also set on a write, before the response. No write-back occurs when both bits are already as required, nor on any fault.
- R9: One translation is in flight at a time. A held response, read request or write-back keeps its values until its ready is high.
- R10: `ctx_load` replaces both bases and both bounds at the clock edge. A request accepted at that same edge is checked and walked with the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctx_load | input | 1 | Load all four context registers |
| ctx_lo_base | input | TA_W | Low-region table base |
| ctx_lo_limit | input | VA_W-OFF_W | Highest page number allowed in the low region |
| ctx_hi_base | input | TA_W | High-region table base |
| ctx_hi_limit | input | VA_W-OFF_W | Lowest page number allowed in the high region |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted on this edge if valid |
| req_vaddr | input | VA_W | Logical address |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 range, 2 invalid, 3 protection |
| mrd_valid | output | 1 | Entry read request |
| mrd_ready | input | 1 | Memory accepts the read |
| mrd_addr | output | TA_W | Entry address |
| mrd_rvalid | input | 1 | Read data returned |
| mrd_rdata | input | PTE_W | Entry contents |
| mwr_valid | output | 1 | Entry write-back request |
| mwr_ready | input | 1 | Memory accepts the write |
| mwr_addr | output | TA_W | Write-back address |
| mwr_data | output | PTE_W | Updated entry |

## Verification
The two functions that can land in one cycle are a context reload and the acceptance of a request. The bench raises `ctx_load` with a tighter low bound in the same cycle as `req_valid` for a page that the old bound allowed. It expects a range fault and no memory read, which shows that the new context governed the walk. Back-pressure is exercised on its own: the memory ready lines alternate, and `rsp_ready` is held low while the response is watched for stability.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_RANGE   = 2'd1,
    FLT_INVALID = 2'd2,
    FLT_PROT    = 2'd3
  } fault_e;

  localparam int PTE_VALID     = 0;
  localparam int PTE_WRITABLE  = 1;
  localparam int PTE_REFERENCE = 2;
  localparam int PTE_DIRTY     = 3;
  localparam int PTE_FRAME_LSB = 4;
endpackage

// File: rtl/xlat_ctx_regs.sv
module xlat_ctx_regs #(
  parameter int VPN_W = 6,
  parameter int TA_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TA_W-1:0]  lo_base_in,
  input  logic [VPN_W-1:0] lo_limit_in,
  input  logic [TA_W-1:0]  hi_base_in,
  input  logic [VPN_W-1:0] hi_limit_in,
  output logic [TA_W-1:0]  lo_base,
  output logic [VPN_W-1:0] lo_limit,
  output logic [TA_W-1:0]  hi_base,
  output logic [VPN_W-1:0] hi_limit
);
  // Reset leaves only page 0 reachable low and only the top page high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_base  <= '0;
      lo_limit <= '0;
      hi_base  <= '0;
      hi_limit <= '1;
    end else if (load) begin
      lo_base  <= lo_base_in;
      lo_limit <= lo_limit_in;
      hi_base  <= hi_base_in;
      hi_limit <= hi_limit_in;
    end
  end
endmodule

// File: rtl/xlat_range.sv
module xlat_range #(
  parameter int VPN_W = 6,
  parameter int TA_W  = 16
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [TA_W-1:0]  lo_base,
  input  logic [VPN_W-1:0] lo_limit,
  input  logic [TA_W-1:0]  hi_base,
  input  logic [VPN_W-1:0] hi_limit,
  output logic             out_of_range,
  output logic [TA_W-1:0]  entry_addr
);
  localparam int PAD_W = TA_W - VPN_W - 2;

  logic            sel_hi;
  logic [TA_W-1:0] base;
  logic [TA_W-1:0] scaled;

  assign sel_hi = vpn[VPN_W-1];
  assign base   = sel_hi ? hi_base : lo_base;

  generate
    if (PAD_W > 0) begin : g_pad
      assign scaled = {{PAD_W{1'b0}}, vpn, 2'b00};
    end else begin : g_nopad
      assign scaled = TA_W'({vpn, 2'b00});
    end
  endgenerate

  assign entry_addr   = base + scaled;
  // High region bound is a floor, low region bound is a ceiling.
  assign out_of_range = sel_hi ? (vpn < hi_limit) : (vpn > lo_limit);
endmodule

// File: rtl/xlat_pte_eval.sv
module xlat_pte_eval
  import xlat_pkg::*;
#(
  parameter int PTE_W   = 32,
  parameter int FRAME_W = 6,
  parameter int OFF_W   = 10
) (
  input  logic [PTE_W-1:0]         pte,
  input  logic                     is_write,
  input  logic [OFF_W-1:0]         offset,
  output fault_e                   fault,
  output logic [PTE_W-1:0]         new_pte,
  output logic                     need_wb,
  output logic [FRAME_W+OFF_W-1:0] paddr
);
  always_comb begin
    fault = FLT_NONE;
    if (!pte[PTE_VALID])
      fault = FLT_INVALID;
    else if (is_write && !pte[PTE_WRITABLE])
      fault = FLT_PROT;
  end

  always_comb begin
    new_pte                = pte;
    new_pte[PTE_REFERENCE] = 1'b1;
    if (is_write)
      new_pte[PTE_DIRTY] = 1'b1;
  end

  assign need_wb = (new_pte != pte);
  assign paddr   = {pte[PTE_FRAME_LSB +: FRAME_W], offset};
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int VA_W  = 16,
  parameter int PA_W  = 16,
  parameter int OFF_W = 10,
  parameter int TA_W  = 16,
  parameter int PTE_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ctx_load,
  input  logic [TA_W-1:0]         ctx_lo_base,
  input  logic [VA_W-OFF_W-1:0]   ctx_lo_limit,
  input  logic [TA_W-1:0]         ctx_hi_base,
  input  logic [VA_W-OFF_W-1:0]   ctx_hi_limit,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-1:0]         req_vaddr,
  input  logic                    req_write,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [PA_W-1:0]         rsp_paddr,
  output logic [1:0]              rsp_fault,
  output logic                    mrd_valid,
  input  logic                    mrd_ready,
  output logic [TA_W-1:0]         mrd_addr,
  input  logic                    mrd_rvalid,
  input  logic [PTE_W-1:0]        mrd_rdata,
  output logic                    mwr_valid,
  input  logic                    mwr_ready,
  output logic [TA_W-1:0]         mwr_addr,
  output logic [PTE_W-1:0]        mwr_data
);
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int FRAME_W = PA_W - OFF_W;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_READ, S_WAIT, S_EVAL, S_WB, S_RESP
  } state_e;

  state_e state_q;

  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [TA_W-1:0]  eaddr_q;
  logic [PTE_W-1:0] pte_q;
  logic [PTE_W-1:0] wbdata_q;
  fault_e           fault_q;
  logic [PA_W-1:0]  paddr_q;

  logic [TA_W-1:0]  lo_base, hi_base;
  logic [VPN_W-1:0] lo_limit, hi_limit;
  logic             oor;
  logic [TA_W-1:0]  entry_addr;
  fault_e           ev_fault;
  logic [PTE_W-1:0] ev_new;
  logic             ev_need_wb;
  logic [PA_W-1:0]  ev_paddr;

  xlat_ctx_regs #(.VPN_W(VPN_W), .TA_W(TA_W)) i_ctx (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (ctx_load),
    .lo_base_in (ctx_lo_base),
    .lo_limit_in(ctx_lo_limit),
    .hi_base_in (ctx_hi_base),
    .hi_limit_in(ctx_hi_limit),
    .lo_base    (lo_base),
    .lo_limit   (lo_limit),
    .hi_base    (hi_base),
    .hi_limit   (hi_limit)
  );

  xlat_range #(.VPN_W(VPN_W), .TA_W(TA_W)) i_range (
    .vpn         (va_q[VA_W-1:OFF_W]),
    .lo_base     (lo_base),
    .lo_limit    (lo_limit),
    .hi_base     (hi_base),
    .hi_limit    (hi_limit),
    .out_of_range(oor),
    .entry_addr  (entry_addr)
  );

  xlat_pte_eval #(.PTE_W(PTE_W), .FRAME_W(FRAME_W), .OFF_W(OFF_W)) i_eval (
    .pte     (pte_q),
    .is_write(wr_q),
    .offset  (va_q[OFF_W-1:0]),
    .fault   (ev_fault),
    .new_pte (ev_new),
    .need_wb (ev_need_wb),
    .paddr   (ev_paddr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      va_q     <= '0;
      wr_q     <= 1'b0;
      eaddr_q  <= '0;
      pte_q    <= '0;
      wbdata_q <= '0;
      fault_q  <= FLT_NONE;
      paddr_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          wr_q    <= req_write;
          state_q <= S_CHECK;
        end
        S_CHECK: begin
          if (oor) begin
            fault_q <= FLT_RANGE;
            paddr_q <= '0;
            state_q <= S_RESP;
          end else begin
            eaddr_q <= entry_addr;
            state_q <= S_READ;
          end
        end
        S_READ: if (mrd_ready) state_q <= S_WAIT;
        S_WAIT: if (mrd_rvalid) begin
          pte_q   <= mrd_rdata;
          state_q <= S_EVAL;
        end
        S_EVAL: begin
          fault_q <= ev_fault;
          if (ev_fault != FLT_NONE) begin
            paddr_q <= '0;
            state_q <= S_RESP;
          end else begin
            paddr_q  <= ev_paddr;
            wbdata_q <= ev_new;
            state_q  <= ev_need_wb ? S_WB : S_RESP;
          end
        end
        S_WB:   if (mwr_ready) state_q <= S_RESP;
        S_RESP: if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign mrd_valid = (state_q == S_READ);
  assign mrd_addr  = eaddr_q;
  assign mwr_valid = (state_q == S_WB);
  assign mwr_addr  = eaddr_q;
  assign mwr_data  = wbdata_q;
  assign rsp_valid = (state_q == S_RESP);
  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk
  import xlat_pkg::*;
#(
  parameter int VA_W  = 16,
  parameter int PA_W  = 16,
  parameter int OFF_W = 10,
  parameter int TA_W  = 16,
  parameter int PTE_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [1:0]       rsp_fault,
  input logic             mrd_valid,
  input logic             mrd_ready,
  input logic [TA_W-1:0]  mrd_addr,
  input logic             mwr_valid,
  input logic             mwr_ready,
  input logic [TA_W-1:0]  mwr_addr,
  input logic [PTE_W-1:0] mwr_data
);
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      off_q <= '0;
    else if (req_valid && req_ready) off_q <= req_vaddr[OFF_W-1:0];
  end

  assert_one_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mrd_valid, mwr_valid, rsp_valid}));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_valid && !mrd_ready |=> mrd_valid && $stable(mrd_addr));

  assert_wb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mwr_valid && !mwr_ready |=> mwr_valid && $stable(mwr_addr) && $stable(mwr_data));

  assert_wb_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mwr_valid |-> mwr_data[PTE_VALID] && mwr_data[PTE_REFERENCE]);

  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault != 2'd0) |-> rsp_paddr == '0);

  assert_offset_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault == 2'd0) |-> rsp_paddr[OFF_W-1:0] == off_q);
endmodule

bind xlat_walker xlat_walker_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .TA_W(TA_W), .PTE_W(PTE_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_vaddr(req_vaddr),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault),
  .mrd_valid(mrd_valid),
  .mrd_ready(mrd_ready),
  .mrd_addr (mrd_addr),
  .mwr_valid(mwr_valid),
  .mwr_ready(mwr_ready),
  .mwr_addr (mwr_addr),
  .mwr_data (mwr_data)
);

// File: tb/test_xlat_walker.sv
module test_xlat_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctx_load = 1'b0;
  logic [15:0] ctx_lo_base = '0, ctx_hi_base = '0;
  logic [5:0]  ctx_lo_limit = '0, ctx_hi_limit = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_ready = 1'b1;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mrd_valid, mrd_ready, mrd_rvalid = 1'b0;
  logic [15:0] mrd_addr;
  logic [31:0] mrd_rdata = '0;
  logic        mwr_valid, mwr_ready;
  logic [15:0] mwr_addr;
  logic [31:0] mwr_data;

  logic [31:0] mem [0:255];
  logic        stall = 1'b0, tog = 1'b0;
  logic        poke_en = 1'b0;
  logic [15:0] poke_addr = '0;
  logic [31:0] poke_data = '0;
  int          rd_cnt = 0, wr_cnt = 0;
  logic [15:0] last_rd = '0, last_wr = '0;
  logic [31:0] last_wd = '0;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  assign mrd_ready = !stall || tog;
  assign mwr_ready = !stall || tog;

  always @(posedge clk) begin
    tog        <= ~tog;
    mrd_rvalid <= 1'b0;
    if (poke_en) mem[poke_addr[9:2]] <= poke_data;
    if (mrd_valid && mrd_ready) begin
      mrd_rvalid <= 1'b1;
      mrd_rdata  <= mem[mrd_addr[9:2]];
      rd_cnt     <= rd_cnt + 1;
      last_rd    <= mrd_addr;
    end
    if (mwr_valid && mwr_ready) begin
      mem[mwr_addr[9:2]] <= mwr_data;
      wr_cnt  <= wr_cnt + 1;
      last_wr <= mwr_addr;
      last_wd <= mwr_data;
    end
  end

  xlat_walker i_xlat_walker (
    .clk(clk), .rst_n(rst_n), .ctx_load(ctx_load),
    .ctx_lo_base(ctx_lo_base), .ctx_lo_limit(ctx_lo_limit),
    .ctx_hi_base(ctx_hi_base), .ctx_hi_limit(ctx_hi_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .mrd_valid(mrd_valid),
    .mrd_ready(mrd_ready), .mrd_addr(mrd_addr), .mrd_rvalid(mrd_rvalid),
    .mrd_rdata(mrd_rdata), .mwr_valid(mwr_valid), .mwr_ready(mwr_ready),
    .mwr_addr(mwr_addr), .mwr_data(mwr_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = a; poke_data = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic set_ctx(input logic [15:0] lb, input logic [5:0] ll,
                         input logic [15:0] hb, input logic [5:0] hl);
    @(negedge clk);
    ctx_load = 1'b1; ctx_lo_base = lb; ctx_lo_limit = ll;
    ctx_hi_base = hb; ctx_hi_limit = hl;
    @(negedge clk);
    ctx_load = 1'b0;
  endtask

  // Waits for the response at a falling edge; leaves it there unconsumed.
  task automatic wait_rsp();
    for (int i = 0; i < 100; i++) begin
      if (rsp_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic xlat(input logic [15:0] va, input logic wr,
                      output logic [1:0] f, output logic [15:0] pa,
                      output int nrd, output int nwr);
    int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp();
    f = rsp_fault; pa = rsp_paddr;
    @(negedge clk);
    nrd = rd_cnt - r0; nwr = wr_cnt - w0;
  endtask

  task automatic t_reset();
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 mrd_valid", 32'(mrd_valid), 32'd0);
    chk("R1 mwr_valid", 32'(mwr_valid), 32'd0);
  endtask

  task automatic t_basic();
    logic [1:0] f; logic [15:0] pa; int nr, nw;
    xlat(16'h082A, 1'b0, f, pa, nr, nw);
    chk("R7 fault", 32'(f), 32'd0);
    chk("R7 paddr", 32'(pa), 32'h142A);
    chk("R4 entry addr", 32'(last_rd), 32'h0108);
    chk("R8 wb count", 32'(nw), 32'd1);
    chk("R8 wb data", last_wd, 32'h57);
    chk("R8 wb addr", 32'(last_wr), 32'h0108);
    xlat(16'h0800, 1'b0, f, pa, nr, nw);
    chk("R8 no wb when unchanged", 32'(nw), 32'd0);
    chk("R7 paddr second", 32'(pa), 32'h1400);
    xlat(16'h0BFF, 1'b1, f, pa, nr, nw);
    chk("R8 write fault", 32'(f), 32'd0);
    chk("R8 dirty wb data", last_wd, 32'h5F);
    chk("R8 dirty wb count", 32'(nw), 32'd1);
    chk("R7 paddr write", 32'(pa), 32'h17FF);
  endtask

  task automatic t_low_range();
    logic [1:0] f; logic [15:0] pa; int nr, nw;
    xlat(16'h1FFF, 1'b0, f, pa, nr, nw);
    chk("R2 at bound fault", 32'(f), 32'd0);
    chk("R2 at bound paddr", 32'(pa), 32'h27FF);
    xlat(16'h2000, 1'b0, f, pa, nr, nw);
    chk("R2 beyond bound fault", 32'(f), 32'd1);
    chk("R2 no read", 32'(nr), 32'd0);
    chk("R5 range paddr zero", 32'(pa), 32'd0);
  endtask

  task automatic t_high_range();
    logic [1:0] f; logic [15:0] pa; int nr, nw;
    xlat(16'hF155, 1'b0, f, pa, nr, nw);
    chk("R3 at bound fault", 32'(f), 32'd0);
    chk("R3 at bound paddr", 32'(pa), 32'hE955);
    chk("R4 high entry addr", 32'(last_rd), 32'h02F0);
    chk("R8 high wb data", last_wd, 32'h3A7);
    xlat(16'hEC00, 1'b1, f, pa, nr, nw);
    chk("R3 below bound fault", 32'(f), 32'd1);
    chk("R3 no read", 32'(nr), 32'd0);
  endtask

  task automatic t_invalid_prot();
    logic [1:0] f; logic [15:0] pa; int nr, nw;
    xlat(16'h0C10, 1'b0, f, pa, nr, nw);
    chk("R5 invalid fault", 32'(f), 32'd2);
    chk("R5 invalid paddr", 32'(pa), 32'd0);
    chk("R8 no wb on invalid", 32'(nw), 32'd0);
    xlat(16'h1010, 1'b1, f, pa, nr, nw);
    chk("R6 prot fault", 32'(f), 32'd3);
    chk("R6 prot read count", 32'(nr), 32'd1);
    chk("R8 no wb on prot", 32'(nw), 32'd0);
    xlat(16'h1010, 1'b0, f, pa, nr, nw);
    chk("R6 read of readonly", 32'(f), 32'd0);
    chk("R6 readonly paddr", 32'(pa), 32'h1810);
    chk("R6 readonly wb", last_wd, 32'h65);
  endtask

  task automatic t_backpressure();
    logic [1:0] f; logic [15:0] pa;
    stall = 1'b1; rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 16'h1C01; req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 busy not ready", 32'(req_ready), 32'd0);
    wait_rsp();
    f = rsp_fault; pa = rsp_paddr;
    repeat (3) @(negedge clk);
    chk("R9 rsp held valid", 32'(rsp_valid), 32'd1);
    chk("R9 rsp held paddr", 32'(rsp_paddr), 32'(pa));
    chk("R9 rsp paddr value", 32'(pa), 32'h2401);
    chk("R9 rsp held fault", 32'(rsp_fault), 32'(f));
    chk("R9 no accept while held", 32'(req_ready), 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 rsp consumed", 32'(rsp_valid), 32'd0);
    chk("R8 dirty after stall", last_wd, 32'h9F);
    stall = 1'b0;
  endtask

  task automatic t_ctx_same_cycle();
    int r0;
    r0 = rd_cnt;
    @(negedge clk);
    ctx_load = 1'b1; ctx_lo_base = 16'h0100; ctx_lo_limit = 6'd1;
    ctx_hi_base = 16'h0200; ctx_hi_limit = 6'd60;
    req_valid = 1'b1; req_vaddr = 16'h082A; req_write = 1'b0;
    @(negedge clk);
    ctx_load = 1'b0; req_valid = 1'b0;
    wait_rsp();
    chk("R10 new bound applies", 32'(rsp_fault), 32'd1);
    @(negedge clk);
    chk("R10 no read", 32'(rd_cnt - r0), 32'd0);
    set_ctx(16'h0100, 6'd7, 16'h0200, 6'd60);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    poke(16'h0108, 32'h53);   // page 2 -> frame 5, writable
    poke(16'h011C, 32'h93);   // page 7 -> frame 9, writable
    poke(16'h010C, 32'h00);   // page 3 invalid
    poke(16'h0110, 32'h61);   // page 4 -> frame 6, read-only
    poke(16'h02F0, 32'h3A3);  // page 60 -> frame 58, writable
    set_ctx(16'h0100, 6'd7, 16'h0200, 6'd60);
    t_basic();
    t_low_range();
    t_high_range();
    t_invalid_prot();
    t_backpressure();
    t_ctx_same_cycle();
    finish_run();
  end
endmodule